// File: doc/BRIEF.md
# Vector Magnitude Engine

This unit returns the integer Euclidean length of a vector whose components are 32-bit two's-complement numbers. A start pulse starts a job and gives the number of components. The components then arrive one per accepted beat on a stream with a valid flag. The unit squares the absolute value of each component and adds it to a wide running sum.

After the last component has been summed, a restoring digit-by-digit square root processes that sum one step per clock. The unit then raises a one-cycle completion pulse. At the same time it presents the 36-bit floor of the root, and that value stays on the output until the next job completes.

A job may hold up to 256 components. The sum register has enough headroom that 256 components of the largest possible magnitude cannot overflow it. The root search first skips the leading trial positions that lie above the sum, then resolves the remaining digits one per cycle.

Top module: `vec_magnitude`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `busy_o` and `done_o` are 0 and `mag_o` is 0.
- R2: A `start_i` pulse while `busy_o` is low begins a job, and `busy_o` is 1 on the next cycle. A `start_i` pulse while `busy_o` is high is ignored, and the running job's result is unchanged.
- R3: Components are taken only while a job is collecting, on cycles with `elem_valid_i` = 1. Exactly `count_i` components are taken. Components presented while idle, on cycles with valid low, or after the count is reached have no effect on the result.
- R4: Each component is read as two's-complement. Its absolute value is squared, so -3 contributes 9 and 32'h80000000 contributes 2^62.
- R5: `mag_o` equals floor(sqrt(sum of squares)) bit-exactly. For example, components {1,2} give 2 and {2,3,6} give 7.
- R6: A count of 0, or a vector of all-zero components, gives `mag_o` = 0 and still produces a `done_o` pulse.
- R7: `done_o` is high for exactly one cycle per job. In that cycle `busy_o` is already low, having been high on the cycle before.
- R8: `mag_o` changes only in a cycle where `done_o` is high, and otherwise holds its value.
- R9: A job of 256 components summed without overflow gives the exact root. Components of 32'h80000000 give 2^35, and components of 32'h7FFFFFFF give 34359738352.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a job when the unit is idle |
| count_i | input | 9 | Number of components in the job, 0 to 256 |
| elem_valid_i | input | 1 | Marks `elem_i` as a component to take |
| elem_i | input | 32 | Signed vector component |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mag_o | output | 36 | Floor of the Euclidean length |

## Verification
The assertions check four properties on every cycle:
- an idle start always raises busy;
- the completion pulse lasts one cycle;
- the completion pulse coincides with busy falling;
- the magnitude moves only on completion.

The arithmetic can only be shown by the bench's scenarios. These cover the exact floor of the root, signed and extreme components, and the 256-component headroom. The bench also covers the filtering of stray components and the rejection of a second start while busy, because both show up only in the final magnitude.

// File: rtl/vmag_pkg.sv
package vmag_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_LOAD,
    ST_ROOT
  } vmag_state_e;

  typedef enum logic [1:0] {
    RT_IDLE,
    RT_SCAN,
    RT_STEP
  } vmag_root_e;

endpackage

// File: rtl/vmag_ctrl.sv
module vmag_ctrl
  import vmag_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             elem_valid_i,
  input  logic             root_fin_i,
  output logic             clr_o,
  output logic             acc_en_o,
  output logic             root_load_o,
  output logic             busy_o
);

  vmag_state_e      state_q;
  logic [CNT_W-1:0] left_q;

  always_comb begin
    clr_o       = (state_q == ST_IDLE) && start_i;
    acc_en_o    = (state_q == ST_ACC) && elem_valid_i;
    root_load_o = (state_q == ST_LOAD);
    busy_o      = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            left_q  <= count_i;
            state_q <= (count_i == '0) ? ST_LOAD : ST_ACC;
          end
        end
        ST_ACC: begin
          if (elem_valid_i) begin
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) state_q <= ST_LOAD;
          end
        end
        ST_LOAD: state_q <= ST_ROOT;
        ST_ROOT: begin
          if (root_fin_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vmag_sumsq.sv
module vmag_sumsq #(
  parameter int ELEM_W = 32,
  parameter int ACC_W  = 72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [ELEM_W-1:0] elem_i,
  output logic [ACC_W-1:0]  sum_o
);

  localparam int SQ_W  = 2 * ELEM_W;
  localparam int PAD_W = ACC_W - SQ_W;

  logic [ELEM_W-1:0] abs_v;
  logic [SQ_W-1:0]   sq_v;
  logic [ACC_W-1:0]  acc_q;

  always_comb begin
    abs_v = elem_i[ELEM_W-1] ? ((~elem_i) + ELEM_W'(1)) : elem_i;
    sq_v  = {{ELEM_W{1'b0}}, abs_v} * {{ELEM_W{1'b0}}, abs_v};
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      acc_q <= '0;
    end else if (en_i) begin
      acc_q <= acc_q + {{PAD_W{1'b0}}, sq_v};
    end
  end

  assign sum_o = acc_q;

endmodule

// File: rtl/vmag_isqrt.sv
module vmag_isqrt
  import vmag_pkg::*;
#(
  parameter int ACC_W = 72
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [ACC_W-1:0]   sum_i,
  output logic               fin_o,
  output logic [ACC_W/2-1:0] root_o
);

  localparam int ROOT_W = ACC_W / 2;
  localparam logic [ACC_W-1:0] TRIAL_TOP = ACC_W'(1) << (ACC_W - 2);

  vmag_root_e       phase_q;
  logic [ACC_W-1:0] rem_q;
  logic [ACC_W-1:0] res_q;
  logic [ACC_W-1:0] trial_q;
  logic [ACC_W-1:0] cand;
  logic             unused_hi;

  assign cand      = res_q + trial_q;
  assign root_o    = res_q[ROOT_W-1:0];
  assign unused_hi = ^res_q[ACC_W-1:ROOT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= RT_IDLE;
      rem_q   <= '0;
      res_q   <= '0;
      trial_q <= '0;
      fin_o   <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (load_i) begin
        rem_q   <= sum_i;
        res_q   <= '0;
        trial_q <= TRIAL_TOP;
        phase_q <= RT_SCAN;
      end else begin
        case (phase_q)
          RT_SCAN: begin
            if (trial_q == '0) begin
              phase_q <= RT_IDLE;
              fin_o   <= 1'b1;
            end else if (trial_q > rem_q) begin
              trial_q <= trial_q >> 2;
            end else begin
              phase_q <= RT_STEP;
            end
          end
          RT_STEP: begin
            if (trial_q == '0) begin
              phase_q <= RT_IDLE;
              fin_o   <= 1'b1;
            end else begin
              if (rem_q >= cand) begin
                rem_q <= rem_q - cand;
                res_q <= (res_q >> 1) + trial_q;
              end else begin
                res_q <= res_q >> 1;
              end
              trial_q <= trial_q >> 2;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/vec_magnitude.sv
module vec_magnitude #(
  parameter int ELEM_W    = 32,
  parameter int MAX_ELEMS = 256,
  localparam int CNT_W    = $clog2(MAX_ELEMS + 1),
  localparam int GUARD_W  = $clog2(MAX_ELEMS),
  localparam int ACC_W    = 2 * ELEM_W + GUARD_W,
  localparam int ROOT_W   = ACC_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              elem_valid_i,
  input  logic [ELEM_W-1:0] elem_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ROOT_W-1:0] mag_o
);

  logic              clr, acc_en, root_load, root_fin;
  logic [ACC_W-1:0]  sum;
  logic [ROOT_W-1:0] root;

  vmag_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .count_i      (count_i),
    .elem_valid_i (elem_valid_i),
    .root_fin_i   (root_fin),
    .clr_o        (clr),
    .acc_en_o     (acc_en),
    .root_load_o  (root_load),
    .busy_o       (busy_o)
  );

  vmag_sumsq #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_sumsq (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .en_i   (acc_en),
    .elem_i (elem_i),
    .sum_o  (sum)
  );

  vmag_isqrt #(.ACC_W(ACC_W)) u_isqrt (
    .clk    (clk),
    .rst    (rst),
    .load_i (root_load),
    .sum_i  (sum),
    .fin_o  (root_fin),
    .root_o (root)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      mag_o  <= '0;
    end else begin
      done_o <= root_fin;
      if (root_fin) mag_o <= root;
    end
  end

endmodule

// File: rtl/vmag_chk.sv
module vmag_chk #(
  parameter int ROOT_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ROOT_W-1:0] mag_o
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R8
  mag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(mag_o));

endmodule

bind vec_magnitude vmag_chk #(.ROOT_W(ROOT_W)) u_vmag_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .mag_o   (mag_o)
);

// File: tb/vec_magnitude_bench.sv
`timescale 1ns/1ps
module vec_magnitude_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [8:0]  count_i = '0;
  logic        elem_valid_i = 1'b0;
  logic [31:0] elem_i = '0;
  logic        busy_o, done_o;
  logic [35:0] mag_o;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  logic [31:0] buf_q [256];

  always #2.5 clk = ~clk;

  vec_magnitude u_vec_magnitude (
    .clk (clk), .rst (rst), .start_i (start_i), .count_i (count_i),
    .elem_valid_i (elem_valid_i), .elem_i (elem_i),
    .busy_o (busy_o), .done_o (done_o), .mag_o (mag_o)
  );

  localparam int NV = 9;
  localparam int TV_N [NV] = '{2, 2, 4, 3, 2, 1, 3, 4, 2};
  localparam logic [31:0] TV_E [NV][4] = '{
    '{32'd3, 32'd4, 32'd0, 32'd0},
    '{32'hFFFFFFFD, 32'hFFFFFFFC, 32'd0, 32'd0},
    '{32'd1, 32'd1, 32'd1, 32'd1},
    '{32'd2, 32'd3, 32'd6, 32'd0},
    '{32'd1, 32'd2, 32'd0, 32'd0},
    '{32'h80000000, 32'd0, 32'd0, 32'd0},
    '{32'd0, 32'd0, 32'd0, 32'd0},
    '{32'd5, 32'd5, 32'd5, 32'd5},
    '{32'hFFFFFFFF, 32'd1, 32'd0, 32'd0}
  };
  localparam logic [35:0] TV_X [NV] = '{
    36'd5, 36'd5, 36'd2, 36'd7, 36'd2, 36'd2147483648, 36'd0, 36'd10, 36'd1
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] ref_sum(input int n);
    logic [71:0] s = '0;
    for (int i = 0; i < n; i++) begin
      longint v = longint'($signed(buf_q[i]));
      if (v < 0) v = -v;
      s = s + 72'(v * v);
    end
    return s;
  endfunction

  function automatic logic [35:0] ref_root(input logic [71:0] s);
    logic [36:0] lo = '0;
    logic [36:0] hi = 37'h10_0000_0000;
    for (int it = 0; it < 40; it++) begin
      logic [36:0] mid;
      logic [73:0] sq;
      if (hi - lo > 37'd1) begin
        mid = (lo + hi) >> 1;
        sq  = {37'b0, mid} * {37'b0, mid};
        if (sq <= {2'b0, s}) lo = mid; else hi = mid;
      end
    end
    return lo[35:0];
  endfunction

  task automatic run(input int n, input bit mid_start, input int extra,
                     output logic [35:0] got);
    int w;
    @(negedge clk);
    start_i = 1'b1; count_i = 9'(n); elem_valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", 64'(busy_o), 64'd1);
    for (int i = 0; i < n; i++) begin
      if (mid_start && i == 1) begin
        elem_valid_i = 1'b0; elem_i = 32'h0000DEAD; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
      elem_valid_i = 1'b1; elem_i = buf_q[i];
      @(negedge clk);
    end
    for (int i = 0; i < extra; i++) begin
      elem_valid_i = 1'b1; elem_i = 32'h00012345;
      @(negedge clk);
    end
    elem_valid_i = 1'b0;
    w = 0;
    while (!done_o && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk("R7 done seen", 64'(done_o), 64'd1);
    chk("R7 busy low at done", 64'(busy_o), 64'd0);
    got = mag_o;
    @(negedge clk);
    chk("R7 done one cycle", 64'(done_o), 64'd0);
    chk("R8 mag held after done", 64'(mag_o), 64'(got));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [35:0] got;
    logic [35:0] prev;
    logic [31:0] lcg;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 64'(busy_o), 64'd0);
    chk("R1 done in reset", 64'(done_o), 64'd0);
    chk("R1 mag in reset", 64'(mag_o), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy_o), 64'd0);
    chk("R1 mag after reset", 64'(mag_o), 64'd0);

    // Table of vectors with expected roots (R4, R5, R6)
    for (int r = 0; r < NV; r++) begin
      for (int k = 0; k < 4; k++) buf_q[k] = TV_E[r][k];
      run(TV_N[r], 1'b0, 0, got);
      if (r == 1 || r == 5 || r == 8) chk("R4 signed row", 64'(got), 64'(TV_X[r]));
      else if (r == 6) chk("R6 zero vector", 64'(got), 64'(TV_X[r]));
      else chk("R5 table row", 64'(got), 64'(TV_X[r]));
    end

    // R3 components while idle are ignored
    for (int i = 0; i < 3; i++) begin
      elem_valid_i = 1'b1; elem_i = 32'd99;
      @(negedge clk);
      chk("R3 idle element keeps idle", 64'(busy_o), 64'd0);
    end
    elem_valid_i = 1'b0;
    buf_q[0] = 32'd3; buf_q[1] = 32'd4;
    run(2, 1'b0, 0, got);
    chk("R3 idle stray components", 64'(got), 64'd5);

    // R2 start while busy ignored, R3 valid gap skipped
    buf_q[0] = 32'd2; buf_q[1] = 32'd3; buf_q[2] = 32'd6;
    run(3, 1'b1, 0, got);
    chk("R2 mid-job start ignored", 64'(got), 64'd7);

    // R3 components after count ignored
    buf_q[0] = 32'd3; buf_q[1] = 32'd4;
    run(2, 1'b0, 3, got);
    chk("R3 extra components", 64'(got), 64'd5);

    // R8 magnitude held while idle
    prev = got;
    repeat (10) @(negedge clk);
    chk("R8 mag held idle", 64'(mag_o), 64'(prev));

    // R6 count zero
    buf_q[0] = 32'd77;
    run(0, 1'b0, 0, got);
    chk("R6 count zero", 64'(got), 64'd0);

    // R9 full-length extremes
    for (int i = 0; i < 256; i++) buf_q[i] = 32'h80000000;
    run(256, 1'b0, 0, got);
    chk("R9 256 x min", 64'(got), 64'h8_0000_0000);
    for (int i = 0; i < 256; i++) buf_q[i] = 32'h7FFFFFFF;
    run(256, 1'b0, 0, got);
    chk("R9 256 x max", 64'(got), 64'd34359738352);

    // R5 pseudo-random vectors against floor-root reference
    lcg = 32'h1234_5678;
    for (int t = 0; t < 6; t++) begin
      int n;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      n = 1 + int'(lcg[15:8]);
      for (int i = 0; i < n; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        buf_q[i] = (t[0]) ? lcg : (lcg >> (t * 5));
      end
      run(n, 1'b0, 0, got);
      chk("R5 random vector", 64'(got), 64'(ref_root(ref_sum(n))));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule